// File: doc/BRIEF.md
# Crosspoint Serial Configuration Receiver

This block is the control-side front end of a 16-output video crosspoint. It takes a three-wire serial stream (clock, active-low enable, data) and turns it into routing commands for a separate latch bank that drives the switch matrix. A mode input selects one of two loading styles. In chain mode, a 96-bit shift register collects a full matrix image, six bits per output. The bit shifted out of its far end goes to the serial output, so several devices can be cascaded and loaded from one long stream. In addressed mode, a short command word is captured. The serial input is wired straight through to the serial output, so every device on a shared bus receives the same word at the same time. Only the device whose strapped address matches the word acts on it.

All pins are brought into the system clock domain through two-flop synchronizers. Serial-clock falling edges and update falling edges are detected after synchronization. Each update edge yields a one-cycle load strobe for the latch bank, together with a flag telling which mode was active at that edge. In addressed mode the strobe is issued only for a matching word. An active-low match output gives the address result while the update input is held low.

Top module: `xbar_cfg_rx`

## Requirements
- R1: A data bit is taken only on a falling edge of ser_clk while ser_en_n is low. Edges seen while ser_en_n is high leave both registers and ser_dout unchanged.
- R2: With mode_chain high, bits shift through a 96-bit register, and ser_dout presents each bit again after 96 further falling edges (ser_dout shows bit k after edge k+96).
- R3: With mode_chain low, ser_dout follows ser_din combinationally.
- R4: In addressed mode the captured 16-bit word, sent most significant bit first, decodes as follows: bits 15-14 ignored, bits 13-10 device address, bits 9-6 output select (w_osel), bit 5 enable (w_en), bit 4 gain (w_gain), bits 3-0 input select (w_src).
- R5: match_n is low only when mode_chain is low, update is low, and word bits 13-10 equal strap_addr. It stays high in chain mode.
- R6: In the chain image, the first six bits shifted belong to output 15 (img[95:90]) and the last six to output 0 (img[5:0]). Within each group the order from most to least significant is enable, gain, then input select bits 3 down to 0.
- R7: Each falling edge of upd_n gives a one-cycle load_stb. In chain mode the strobe is unconditional. In addressed mode it is given only on an address match. load_chain holds the mode seen at the last strobe.
- R8: After reset img and the word fields are zero, match_n is high and load_stb is low.
- R9: When two devices are chained and 192 bits are sent, the first 96 bits end up in the second device and the last 96 in the first.
- R10: Shifting in one mode leaves the other mode's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data taken on its falling edge |
| ser_en_n | input | 1 | Active-low serial enable |
| ser_din | input | 1 | Serial data in |
| mode_chain | input | 1 | 1 = 96-bit chain mode, 0 = addressed word mode |
| upd_n | input | 1 | Active-low update strobe |
| strap_addr | input | 4 | Strapped device address |
| ser_dout | output | 1 | Serial data out (chain tail or pass-through) |
| match_n | output | 1 | Active-low address match, qualified by update |
| load_stb | output | 1 | One-cycle load strobe to the latch bank |
| load_chain | output | 1 | Mode active at the last load strobe |
| img | output | 96 | Chain-mode matrix image, output 15 in the top group |
| w_osel | output | 4 | Addressed word: output select |
| w_en | output | 1 | Addressed word: output enable |
| w_gain | output | 1 | Addressed word: gain select |
| w_src | output | 4 | Addressed word: input select |

## Verification
A slip of one position in the chain register shows at ser_dout one serial edge too early or too late. In a cascade, it corrupts every bit that reaches the second device, so it appears at the first update after 192 bits. A wrong field slice in the word register shows on the decoded field ports as soon as one addressed word is loaded, and a wrong address compare shows on match_n within the same update pulse. A missing enable qualification changes img or the word fields right after the ignored edges, before any update.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
  localparam int SRC_W    = 4;
  localparam int N_OUT    = 16;
  localparam int GRP_W    = SRC_W + 2;
  localparam int IMG_W    = N_OUT * GRP_W;
  localparam int ADDR_W   = 4;
  localparam int OSEL_W   = 4;
  localparam int PAD_W    = 2;
  localparam int WORD_W   = PAD_W + ADDR_W + OSEL_W + GRP_W;
  localparam int WCAP_W   = WORD_W - PAD_W;
  localparam int OSEL_LSB = GRP_W;
  localparam int ADDR_LSB = GRP_W + OSEL_W;
  localparam int SYNC_N   = 2;

  // pin bundle positions inside the synchronizer vector
  localparam int P_SCLK = 0;
  localparam int P_EN   = 1;
  localparam int P_DIN  = 2;
  localparam int P_UPD  = 3;
  localparam int P_MODE = 4;
  localparam int P_W    = 5;

  typedef struct packed {
    logic             en;
    logic             gain;
    logic [SRC_W-1:0] src;
  } route_t;

  function automatic route_t word_route(input logic [WCAP_W-1:0] w);
    return route_t'(w[GRP_W-1:0]);
  endfunction

  function automatic logic [OSEL_W-1:0] word_osel(input logic [WCAP_W-1:0] w);
    return w[OSEL_LSB +: OSEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [WCAP_W-1:0] w);
    return w[ADDR_LSB +: ADDR_W];
  endfunction
endpackage

// File: rtl/xcfg_sync.sv
module xcfg_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/xcfg_chain.sv
module xcfg_chain
  import xcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             din,
  output logic [IMG_W-1:0] img,
  output logic             tail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     img <= '0;
    else if (shift) img <= {img[IMG_W-2:0], din};
  end

  assign tail = img[IMG_W-1];

  // R2
  chain_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (img[0] == $past(din)) && (tail == $past(img[IMG_W-2])));

  // R1
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(img));
endmodule

// File: rtl/xcfg_word.sv
module xcfg_word
  import xcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              din,
  input  logic [ADDR_W-1:0] strap,
  output logic [WCAP_W-1:0] word,
  output logic              addr_hit
);
  // the two ignored top bits simply fall off the end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (shift) word <= {word[WCAP_W-2:0], din};
  end

  assign addr_hit = (word_addr(word) == strap);

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(word));

  // R4
  word_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> word[0] == $past(din));
endmodule

// File: rtl/xbar_cfg_rx.sv
module xbar_cfg_rx
  import xcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_en_n,
  input  logic              ser_din,
  input  logic              mode_chain,
  input  logic              upd_n,
  input  logic [ADDR_W-1:0] strap_addr,
  output logic              ser_dout,
  output logic              match_n,
  output logic              load_stb,
  output logic              load_chain,
  output logic [IMG_W-1:0]  img,
  output logic [OSEL_W-1:0] w_osel,
  output logic              w_en,
  output logic              w_gain,
  output logic [SRC_W-1:0]  w_src
);
  localparam logic [P_W-1:0] SYNC_RST = P_W'((1 << P_EN) | (1 << P_UPD));

  logic [P_W-1:0] pin_raw, pin_s;
  logic sclk_q, upd_q;
  logic sclk_fall, upd_fall, shift_edge, chain_shift, word_shift;
  logic mode_s, upd_low, chain_tail, addr_hit;
  logic [WCAP_W-1:0] word;
  route_t wr;

  always_comb begin
    pin_raw         = '0;
    pin_raw[P_SCLK] = ser_clk;
    pin_raw[P_EN]   = ser_en_n;
    pin_raw[P_DIN]  = ser_din;
    pin_raw[P_UPD]  = upd_n;
    pin_raw[P_MODE] = mode_chain;
  end

  xcfg_sync #(.W(P_W), .STAGES(SYNC_N), .RST(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      upd_q  <= 1'b1;
    end else begin
      sclk_q <= pin_s[P_SCLK];
      upd_q  <= pin_s[P_UPD];
    end
  end

  assign mode_s      = pin_s[P_MODE];
  assign upd_low     = ~pin_s[P_UPD];
  assign sclk_fall   = sclk_q & ~pin_s[P_SCLK];
  assign upd_fall    = upd_q & upd_low;
  assign shift_edge  = sclk_fall & ~pin_s[P_EN];
  assign chain_shift = shift_edge & mode_s;
  assign word_shift  = shift_edge & ~mode_s;

  xcfg_chain u_chain (
    .clk(clk), .rst_n(rst_n), .shift(chain_shift), .din(pin_s[P_DIN]),
    .img(img), .tail(chain_tail)
  );

  xcfg_word u_word (
    .clk(clk), .rst_n(rst_n), .shift(word_shift), .din(pin_s[P_DIN]),
    .strap(strap_addr), .word(word), .addr_hit(addr_hit)
  );

  assign ser_dout = mode_s ? chain_tail : ser_din;
  assign match_n  = ~(~mode_s & upd_low & addr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_stb   <= 1'b0;
      load_chain <= 1'b0;
    end else begin
      load_stb <= upd_fall & (mode_s | addr_hit);
      if (upd_fall) load_chain <= mode_s;
    end
  end

  assign wr     = word_route(word);
  assign w_osel = word_osel(word);
  assign w_en   = wr.en;
  assign w_gain = wr.gain;
  assign w_src  = wr.src;

  // R7
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  // R5
  match_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !load_chain) |-> $past(!match_n));

  // R7
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_stb) |-> $past(upd_fall));
endmodule

// File: tb/sim_xbar_cfg_rx.sv
module sim_xbar_cfg_rx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk, en_n, din, mode, upd_n;
  logic d0, d1, m0n, m1n, l0, l1, lc0, lc1, we0, we1, wg0, wg1;
  logic [95:0] img0, img1, e0, e1;
  logic [3:0] os0, os1, ws0, ws1;
  logic [15:0] ew;
  int total = 0, bad = 0, nl0 = 0, nl1 = 0;

  xbar_cfg_rx u0 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_en_n(en_n),
    .ser_din(din), .mode_chain(mode), .upd_n(upd_n), .strap_addr(4'd5),
    .ser_dout(d0), .match_n(m0n), .load_stb(l0), .load_chain(lc0), .img(img0),
    .w_osel(os0), .w_en(we0), .w_gain(wg0), .w_src(ws0));
  xbar_cfg_rx u1 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_en_n(en_n),
    .ser_din(d0), .mode_chain(mode), .upd_n(upd_n), .strap_addr(4'd9),
    .ser_dout(d1), .match_n(m1n), .load_stb(l1), .load_chain(lc1), .img(img1),
    .w_osel(os1), .w_en(we1), .w_gain(wg1), .w_src(ws1));

  always @(posedge clk) if (rst_n) begin
    if (l0) nl0++;
    if (l1) nl1++;
  end

  // {u1 match, u0 match, word}; u0 strap 5, u1 strap 9
  localparam logic [17:0] VEC [5] = '{
    {2'b01, 16'h14EA}, {2'b10, 16'h27D3}, {2'b00, 16'hCC3F},
    {2'b01, 16'h9737}, {2'b10, 16'h25A0}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [95:0] act,
                     input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic pat(input int i);
    return ((i % 3) == 0) ^ ((i % 5) == 1);
  endfunction

  task automatic send_bit(input logic b);
    din = b; sclk = 1'b1; tick(6);
    sclk = 1'b0; tick(6);
    if (!en_n) begin
      if (mode) begin e1 = {e1[94:0], e0[95]}; e0 = {e0[94:0], b}; end
      else ew = {ew[14:0], b};
    end
  endtask

  task automatic pulse_upd();
    upd_n = 1'b0; tick(6);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_up();
  end

  initial begin
    logic [5:0] g;
    int ml, b0, b1;
    rst_n = 0; sclk = 0; en_n = 1; din = 0; mode = 0; upd_n = 1;
    e0 = '0; e1 = '0; ew = '0;
    tick(3); rst_n = 1; tick(4);
    // R8 reset state
    chk(img0 == '0 && img1 == '0, "R8 img", img0, 0);
    chk(m0n && m1n && !l0, "R8 match/load", {m0n, m1n, l0}, 3'b110);
    chk({os0, we0, wg0, ws0} == 0, "R8 fields", {os0, we0, wg0, ws0}, 0);

    // chain mode, two cascaded devices
    mode = 1; en_n = 0; tick(6);
    for (int i = 0; i < 192; i++) begin
      send_bit(pat(i));
      if (i == 95) chk(d0 == pat(0), "R2 tail after 96", d0, pat(0));
      if (i == 94) chk(d0 == 1'b0, "R2 tail before 96", d0, 0);
    end
    en_n = 1;
    b0 = nl0; b1 = nl1;
    pulse_upd();
    chk(m0n && m1n, "R5 chain mode match high", {m0n, m1n}, 2'b11);
    upd_n = 1; tick(6);
    chk(nl0 == b0 + 1 && nl1 == b1 + 1, "R7 chain strobe", nl0 - b0, 1);
    chk(lc0 && lc1, "R7 load_chain", {lc0, lc1}, 2'b11);
    chk(img0 == e0, "R2 u0 image", img0, e0);
    chk(img1 == e1, "R9 u1 image", img1, e1);
    ml = 0;
    for (int i = 0; i < 96; i++) if (img1[95-i] != pat(i)) ml++;
    chk(ml == 0, "R9 first 96 bits in second device", ml, 0);
    for (int k = 0; k < 6; k++) g[5-k] = pat(k);
    chk(img1[95:90] == g, "R6 first group is output 15", img1[95:90], g);
    for (int k = 0; k < 6; k++) g[5-k] = pat(186 + k);
    chk(img0[5:0] == g, "R6 last group is output 0", img0[5:0], g);

    // R1: enable high, edges ignored
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    chk(img0 == e0 && img1 == e1, "R1 chain ignored", img0, e0);

    // R3 pass-through in addressed mode
    mode = 0; tick(6);
    din = 1; #1; chk(d0 == 1'b1, "R3 pass 1", d0, 1);
    din = 0; #1; chk(d0 == 1'b0, "R3 pass 0", d0, 0);
    tick(1);

    foreach (VEC[v]) begin
      en_n = 0; tick(2);
      for (int i = 15; i >= 0; i--) send_bit(VEC[v][i]);
      en_n = 1; tick(2);
      b0 = nl0; b1 = nl1;
      pulse_upd();
      chk(m0n == !VEC[v][16], "R5 u0 match", m0n, !VEC[v][16]);
      chk(m1n == !VEC[v][17], "R5 u1 match", m1n, !VEC[v][17]);
      chk({os0, we0, wg0, ws0} == VEC[v][9:0], "R4 u0 fields",
          {os0, we0, wg0, ws0}, VEC[v][9:0]);
      chk({os1, we1, wg1, ws1} == VEC[v][9:0], "R4 u1 fields",
          {os1, we1, wg1, ws1}, VEC[v][9:0]);
      upd_n = 1; tick(6);
      chk(nl0 - b0 == int'(VEC[v][16]) && nl1 - b1 == int'(VEC[v][17]),
          "R7 addressed strobe", {nl0 - b0, nl1 - b1}, VEC[v][17:16]);
      chk(m0n && m1n, "R5 match released", {m0n, m1n}, 2'b11);
    end
    chk(!lc0 && !lc1, "R7 load_chain addressed", {lc0, lc1}, 0);
    chk(img0 == e0, "R10 chain image kept", img0, e0);

    // R1 addressed mode: enable high leaves word alone
    for (int i = 15; i >= 0; i--) send_bit(~VEC[4][i]);
    chk({os0, we0, wg0, ws0} == VEC[4][9:0], "R1 word ignored",
        {os0, we0, wg0, ws0}, VEC[4][9:0]);
    chk(ew[9:0] == VEC[4][9:0], "R1 model", ew[9:0], VEC[4][9:0]);

    // R8 reset again
    rst_n = 0; tick(2); rst_n = 1; tick(4);
    chk(img0 == '0 && {os0, we0, wg0, ws0} == 0, "R8 re-reset", img0, 0);
    finish_up();
  end
endmodule